// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream. A chain of stages can be filled at once from a parallel bus. It can also be advanced one position at a time, with a serial input feeding the first stage. The last stage appears on a serial output, and a second output carries the inverse of that stage.

Two interchangeable clock-like inputs are ORed into a single gated shift clock. Either input can serve as the clock while the other serves as an inhibit. An active-low load control takes precedence over shifting.

The block itself runs on a fast system clock. The two clock inputs and the load control are brought in through synchronizers, and shifting happens when the synchronized gated clock is seen to rise. A debug bus shows the contents of every stage.

Top module: `gated_shift_serializer`

## Requirements
- R1: A synchronous active-high `rst` clears every stage to zero.
- R2: While `loadN` is low, the stages follow `parIn` (bit 0 is the first stage, bit WIDTH-1 the last stage), whatever `clkA`, `clkB` and `serIn` do.
- R3: With `loadN` high, a 0-to-1 change of `clkA | clkB` caused by `clkA` rising while `clkB` is low shifts the register once: stage 0 takes `serIn` and stage i takes the old stage i-1.
- R4: The two clock inputs are interchangeable: `clkB` rising while `clkA` is low shifts exactly as in R3.
- R5: A rising edge on one clock input while the other is high causes no shift.
- R6: Without a qualifying rising edge, and with `loadN` high, every stage keeps its value.
- R7: `serOut` equals the last stage and `serOutN` is always its inverse.
- R8: In the first sampled cycle with `loadN` high after a load, the register loads `parIn` once more and does not shift, even if the gated clock rises in that same cycle.
- R9: A change on `clkA`, `clkB` or `loadN` reaches the stages on the third system clock edge after the change: two synchronizer edges, then the stage update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| loadN | input | 1 | Active-low parallel load; high allows shifting |
| clkA | input | 1 | Clock input, interchangeable with clkB |
| clkB | input | 1 | Clock input, interchangeable with clkA |
| serIn | input | 1 | Serial data into the first stage |
| parIn | input | WIDTH | Parallel load word; bit 0 goes to the first stage |
| serOut | output | 1 | Last stage |
| serOutN | output | 1 | Inverse of the last stage |
| stageBus | output | WIDTH | Debug view of all stages |

## Verification
The bench uses the default parameters: eight stages and two synchronizer flops. With these values the full stage bus can be compared against a bench model after every stimulus. Serial data is seen to leave the last stage within eight shifts. The three-edge input latency of R9 can be sampled cycle by cycle, and so can the case in R8 where load release and a clock rise coincide.

// File: rtl/gss_pkg.sv
package gss_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } strobe_t;
endpackage

// File: rtl/gss_sync.sv
module gss_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RESET_VAL;
    else     pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= RESET_VAL;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/gss_control.sv
module gss_control
  import gss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    clkA,
  input  logic    clkB,
  input  logic    loadN,
  output strobe_t strb
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] SYNC_RESET = 3'b100;

  logic [NSIG-1:0] syncBits;
  logic syncA, syncB, syncLoadN;
  logic gated, gatedPrev, loadPrevN;

  gss_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RESET)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({loadN, clkB, clkA}),
    .q   (syncBits)
  );

  assign syncA     = syncBits[0];
  assign syncB     = syncBits[1];
  assign syncLoadN = syncBits[2];
  assign gated     = syncA | syncB;

  always_ff @(posedge clk) begin
    if (rst) begin
      gatedPrev <= 1'b0;
      loadPrevN <= 1'b1;
    end else begin
      gatedPrev <= gated;
      loadPrevN <= syncLoadN;
    end
  end

  always_comb begin
    strb.load  = ~syncLoadN | ~loadPrevN;
    strb.shift = syncLoadN & loadPrevN & gated & ~gatedPrev;
  end

  // R5: a rise needs a low gated clock first, so shifts never come back to back
  a_r5_single_shift: assert property (@(posedge clk) disable iff (rst)
    strb.shift |=> !strb.shift);

  // R8: the cycle in which the synchronized load control goes high never shifts
  a_r8_release_no_shift: assert property (@(posedge clk) disable iff (rst)
    $rose(syncLoadN) |-> !strb.shift);
endmodule

// File: rtl/gss_datapath.sv
module gss_datapath
  import gss_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stages
);
  always_ff @(posedge clk) begin
    if (rst)             stages <= '0;
    else if (strb.load)  stages <= parIn;
    else if (strb.shift) stages <= {stages[WIDTH-2:0], serIn};
  end

  a_r2_load_follows: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> stages == $past(parIn));

  a_r3_shift_moves: assert property (@(posedge clk) disable iff (rst)
    (strb.shift && !strb.load) |=> stages == {$past(stages[WIDTH-2:0]), $past(serIn)});

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!strb.shift && !strb.load) |=> $stable(stages));
endmodule

// File: rtl/gated_shift_serializer.sv
module gated_shift_serializer
  import gss_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadN,
  input  logic             clkA,
  input  logic             clkB,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic             serOut,
  output logic             serOutN,
  output logic [WIDTH-1:0] stageBus
);
  strobe_t strb;
  logic [WIDTH-1:0] stages;

  gss_control #(.SYNC_STAGES(SYNC_STAGES)) u_control (
    .clk   (clk),
    .rst   (rst),
    .clkA  (clkA),
    .clkB  (clkB),
    .loadN (loadN),
    .strb  (strb)
  );

  gss_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .serIn  (serIn),
    .parIn  (parIn),
    .stages (stages)
  );

  assign serOut   = stages[WIDTH-1];
  assign serOutN  = ~stages[WIDTH-1];
  assign stageBus = stages;
endmodule

// File: tb/gated_shift_serializer_bench.sv
module gated_shift_serializer_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadN = 1'b1;
  logic clkA = 1'b0;
  logic clkB = 1'b0;
  logic serIn = 1'b0;
  logic [W-1:0] parIn = '0;
  logic serOut, serOutN;
  logic [W-1:0] stageBus;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] model = '0;

  always #5 clk = ~clk;

  gated_shift_serializer #(.WIDTH(W), .SYNC_STAGES(2)) u_gated_shift_serializer (
    .clk(clk), .rst(rst), .loadN(loadN), .clkA(clkA), .clkB(clkB),
    .serIn(serIn), .parIn(parIn), .serOut(serOut), .serOutN(serOutN),
    .stageBus(stageBus)
  );

  function automatic logic [W-1:0] shiftOnce(logic [W-1:0] cur, logic sin);
    return {cur[W-2:0], sin};
  endfunction

  task automatic check(string req, logic [W-1:0] exp);
    checks++;
    if (stageBus !== exp || serOut !== exp[W-1] || serOutN !== ~exp[W-1]) begin
      fails++;
      $display("FAIL %s: stageBus=%h serOut=%b serOutN=%b expected stageBus=%h serOut=%b serOutN=%b",
               req, stageBus, serOut, serOutN, exp, exp[W-1], ~exp[W-1]);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  // called at a negedge; applies new inputs, updates model, waits for them to take effect
  task automatic drive(logic nA, logic nB, logic nLoadN, logic nSer, logic [W-1:0] nPar);
    logic oldG, newG;
    oldG = clkA | clkB;
    newG = nA | nB;
    if (!nLoadN || !loadN) model = nPar;
    else if (!oldG && newG) model = shiftOnce(model, nSer);
    clkA = nA; clkB = nB; loadN = nLoadN; serIn = nSer; parIn = nPar;
    settle();
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset clears stages", '0);

    // R2: load overrides clocks and serial input
    drive(0, 0, 0, 1, 8'hA5);
    check("R2 load A5", 8'hA5);
    drive(1, 0, 0, 0, 8'hA5);
    check("R2 clkA rise ignored during load", 8'hA5);
    drive(1, 1, 0, 1, 8'h5A);
    check("R2 follows new parIn", 8'h5A);
    drive(0, 0, 0, 1, 8'h5A);
    check("R2 clocks low during load", 8'h5A);
    drive(0, 0, 1, 1, 8'h5A);
    check("R6 release without edge holds", 8'h5A);

    drive(1, 0, 1, 1, 8'h00);
    check("R3 clkA rise shifts", model);
    check("R7 serial outputs", 8'hB5);
    drive(0, 0, 1, 0, 8'h00);
    check("R6 clkA fall no shift", model);
    drive(0, 1, 1, 0, 8'h00);
    check("R4 clkB rise shifts", 8'h6A);

    drive(1, 1, 1, 1, 8'h00);
    check("R5 clkA rise while clkB high", 8'h6A);
    drive(0, 1, 1, 0, 8'h00);
    drive(1, 1, 1, 1, 8'h00);
    check("R5 second gated rise masked", 8'h6A);
    drive(0, 0, 1, 1, 8'h00);
    check("R6 both low hold", 8'h6A);

    // R9 latency: change at negedge, stages update on third posedge
    clkA = 1'b1; serIn = 1'b1;
    model = shiftOnce(model, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 unchanged after two edges", 8'h6A);
    @(posedge clk);
    @(negedge clk);
    check("R9 updated on third edge", 8'hD5);
    settle();
    drive(0, 0, 1, 0, 8'h00);

    // R8: release of load coincides with clock rise
    drive(0, 0, 0, 0, 8'h3C);
    check("R2 load 3C", 8'h3C);
    clkA = 1'b1; loadN = 1'b1; serIn = 1'b1;
    settle();
    check("R8 release with rise counts as load", 8'h3C);
    drive(0, 0, 1, 0, 8'h3C);
    check("R8 no later shift", 8'h3C);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 8;
      if (op == 0) begin
        logic [W-1:0] p;
        p = W'($urandom);
        drive(1'($urandom), 1'($urandom), 0, 1'($urandom), p);
        check("R2 random load", model);
        drive(clkA, clkB, 1, 1'($urandom), p);
        check("R8 random release", model);
      end else if (op < 5) begin
        drive(~clkA, clkB, 1, 1'($urandom), W'($urandom));
        check("R3 random clkA toggle", model);
      end else begin
        drive(clkA, ~clkB, 1, 1'($urandom), W'($urandom));
        check("R4 random clkB toggle", model);
      end
    end

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model = '0;
    @(negedge clk);
    check("R1 reset mid-run", '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule